// File: doc/BRIEF.md
# Operand Effective Address Generator

This block turns the operand specifier of a 16-bit register-based CPU into the location of that operand. It handles one operand per request. The decode stage presents the following on a single cycle with a request strobe: whether this is the source or the destination, the 2-bit addressing-mode field, the register number, the byte/word flag, the extension word that follows the instruction, the current program counter, and the contents of the named register. One cycle later the block answers with a one-cycle result strobe. The result is a register index, a memory address or an immediate value. An illegal-destination flag is raised when the destination mode field cannot be used.

The source side decodes seven modes and the destination side decodes four. The base register number changes the meaning of mode 01. With the program counter it becomes PC-relative. With the absolute-select register it becomes a plain absolute address. With any other register it is register-plus-offset. For source mode 11, the block also asks for the register to be written back, stepped past the operand, in the same cycle as the result strobe. With the program counter as base, that write-back is what makes the immediate form.

Top module: `opnd_ea_gen`

## Requirements
- R1: Mode field 00 (source or destination) gives result kind 0 (register) with `ea_reg` equal to the requested register, `ea_addr` and `ea_imm` zero, and no write-back.
- R2: A destination request with mode field 10 or 11 gives kind 3 with `ea_illegal` set, all of `ea_reg`, `ea_addr`, `ea_imm` zero, and no write-back.
- R3: Mode 01 with a register other than 0 and 2 gives kind 1 (memory) with `ea_addr` = extension word + register contents, modulo 2^16, for source and destination.
- R4: Mode 01 with register 0 gives kind 1 with `ea_addr` = program counter + extension word, modulo 2^16, for source and destination.
- R5: Mode 01 with register 2 gives kind 1 with `ea_addr` equal to the extension word; the contents of register 2 do not enter the result.
- R6: Source mode 11 with register 0 gives kind 2 (immediate) with `ea_imm` equal to the extension word. It writes back register 0 with program counter + 2, for word and byte operations alike.
- R7: Source mode 10 gives kind 1 with `ea_addr` equal to the register contents and no write-back.
- R8: Source mode 11 with a register other than 0 gives kind 1 with `ea_addr` equal to the register's old contents. It writes that register back with old contents + 2 for word operations and + 1 for byte operations, except that register 1 (stack pointer) always steps by 2. The sum wraps modulo 2^16.
- R9: `ea_valid` is high for exactly the one cycle after each cycle with `req_valid` high, and `wb_valid` is only ever high in that same cycle. In any cycle without a request result, every output is zero, and so is any write-back field when no write-back is issued.
- R10: While reset is held and after its release, before any request, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_dst | input | 1 | 1 = destination operand, 0 = source operand |
| req_mode | input | 2 | Addressing-mode field |
| req_reg | input | 4 | Register number |
| req_byte | input | 1 | 1 = byte operation, 0 = word |
| req_ext | input | 16 | Extension word |
| req_pc | input | 16 | Current program counter |
| req_regval | input | 16 | Contents of register `req_reg` |
| ea_valid | output | 1 | One-cycle result strobe |
| ea_kind | output | 2 | 0 register, 1 memory, 2 immediate, 3 illegal |
| ea_reg | output | 4 | Register index for register mode |
| ea_addr | output | 16 | Memory address |
| ea_imm | output | 16 | Immediate value |
| ea_illegal | output | 1 | Destination mode not allowed |
| wb_valid | output | 1 | Register write-back request |
| wb_reg | output | 4 | Register to write back |
| wb_data | output | 16 | Stepped register value |

## Verification
Two functions can land in the same cycle: delivering the memory address and issuing the register write-back, in auto-increment and immediate modes. The bench keeps a register array and feeds it the write-back it sees. Each auto-increment result is judged in a single sample: the address must carry the old register value and the write-back must carry the stepped value, so a step that leaks into the address is caught. The bench then repeats the access and checks that the next address starts from the stepped value. It also issues a write-back request directly followed by a request with no write-back, to show the write-back does not outlast its strobe.

// File: rtl/opnd_ea_pkg.sv
package opnd_ea_pkg;

   typedef enum logic [2:0] {
      EA_REG       = 3'd0,
      EA_INDEXED   = 3'd1,
      EA_SYMBOLIC  = 3'd2,
      EA_ABSOLUTE  = 3'd3,
      EA_INDIRECT  = 3'd4,
      EA_AUTOINC   = 3'd5,
      EA_IMMEDIATE = 3'd6,
      EA_ILLEGAL   = 3'd7
   } ea_mode_e;

   typedef enum logic [1:0] {
      KIND_REG  = 2'd0,
      KIND_MEM  = 2'd1,
      KIND_IMM  = 2'd2,
      KIND_NONE = 2'd3
   } ea_kind_e;

endpackage

// File: rtl/opnd_ea_decode.sv
module opnd_ea_decode
   import opnd_ea_pkg::*;
#(
   parameter int REG_W   = 4,
   parameter int PC_IDX  = 0,
   parameter int ABS_IDX = 2
) (
   input  logic             dst,
   input  logic [1:0]       mode_field,
   input  logic [REG_W-1:0] rn,
   output ea_mode_e         mode
);

   logic is_pc;
   logic is_abs;

   assign is_pc  = (rn == REG_W'(PC_IDX));
   assign is_abs = (rn == REG_W'(ABS_IDX));

   always_comb begin
      unique case (mode_field)
         2'b00:   mode = EA_REG;
         2'b01: begin
            if (is_pc)       mode = EA_SYMBOLIC;
            else if (is_abs) mode = EA_ABSOLUTE;
            else             mode = EA_INDEXED;
         end
         2'b10:   mode = dst ? EA_ILLEGAL : EA_INDIRECT;
         default: mode = dst ? EA_ILLEGAL : (is_pc ? EA_IMMEDIATE : EA_AUTOINC);
      endcase
   end

endmodule

// File: rtl/opnd_ea_addr.sv
module opnd_ea_addr
   import opnd_ea_pkg::*;
#(
   parameter int DATA_W      = 16,
   parameter bit SHARE_ADDER = 1'b1
) (
   input  ea_mode_e          mode,
   input  logic [DATA_W-1:0] ext,
   input  logic [DATA_W-1:0] pc,
   input  logic [DATA_W-1:0] base,
   output ea_kind_e          kind,
   output logic [DATA_W-1:0] addr,
   output logic [DATA_W-1:0] imm
);

   logic [DATA_W-1:0] offset_sum;

   generate
      if (SHARE_ADDER) begin : g_shared
         logic [DATA_W-1:0] add_a;
         assign add_a      = (mode == EA_SYMBOLIC) ? pc : base;
         assign offset_sum = add_a + ext;
      end else begin : g_split
         logic [DATA_W-1:0] sum_idx;
         logic [DATA_W-1:0] sum_pcrel;
         assign sum_idx    = base + ext;
         assign sum_pcrel  = pc + ext;
         assign offset_sum = (mode == EA_SYMBOLIC) ? sum_pcrel : sum_idx;
      end
   endgenerate

   always_comb begin
      kind = KIND_MEM;
      addr = '0;
      imm  = '0;
      unique case (mode)
         EA_REG:       kind = KIND_REG;
         EA_INDEXED,
         EA_SYMBOLIC:  addr = offset_sum;
         EA_ABSOLUTE:  addr = ext;
         EA_INDIRECT,
         EA_AUTOINC:   addr = base;
         EA_IMMEDIATE: begin
            kind = KIND_IMM;
            imm  = ext;
         end
         default:      kind = KIND_NONE;
      endcase
   end

endmodule

// File: rtl/opnd_ea_step.sv
module opnd_ea_step
   import opnd_ea_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int REG_W  = 4,
   parameter int SP_IDX = 1,
   parameter int PC_IDX = 0
) (
   input  ea_mode_e          mode,
   input  logic [REG_W-1:0]  rn,
   input  logic              byte_op,
   input  logic [DATA_W-1:0] base,
   output logic              wb_en,
   output logic [REG_W-1:0]  wb_rn,
   output logic [DATA_W-1:0] wb_val
);

   localparam int WORD_STEP = DATA_W / 8;
   localparam int BYTE_STEP = 1;

   logic              keep_word;
   logic [DATA_W-1:0] step;

   assign keep_word = (rn == REG_W'(SP_IDX)) || (rn == REG_W'(PC_IDX));
   assign step      = (byte_op && !keep_word) ? DATA_W'(BYTE_STEP) : DATA_W'(WORD_STEP);

   always_comb begin
      wb_en  = (mode == EA_AUTOINC) || (mode == EA_IMMEDIATE);
      wb_rn  = wb_en ? rn : '0;
      wb_val = wb_en ? (base + step) : '0;
   end

endmodule

// File: rtl/opnd_ea_gen.sv
module opnd_ea_gen
   import opnd_ea_pkg::*;
#(
   parameter int DATA_W      = 16,
   parameter int REG_CNT     = 16,
   parameter int PC_IDX      = 0,
   parameter int SP_IDX      = 1,
   parameter int ABS_IDX     = 2,
   parameter bit SHARE_ADDER = 1'b1,
   localparam int REG_W      = $clog2(REG_CNT)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_dst,
   input  logic [1:0]        req_mode,
   input  logic [REG_W-1:0]  req_reg,
   input  logic              req_byte,
   input  logic [DATA_W-1:0] req_ext,
   input  logic [DATA_W-1:0] req_pc,
   input  logic [DATA_W-1:0] req_regval,
   output logic              ea_valid,
   output logic [1:0]        ea_kind,
   output logic [REG_W-1:0]  ea_reg,
   output logic [DATA_W-1:0] ea_addr,
   output logic [DATA_W-1:0] ea_imm,
   output logic              ea_illegal,
   output logic              wb_valid,
   output logic [REG_W-1:0]  wb_reg,
   output logic [DATA_W-1:0] wb_data
);

   localparam int WORD_STEP = DATA_W / 8;

   generate
      if (DATA_W < 8 || (DATA_W % 8) != 0) begin : g_bad_width
         $error("opnd_ea_gen: DATA_W must be a non-zero multiple of 8");
      end
      if (REG_CNT < 4) begin : g_bad_regs
         $error("opnd_ea_gen: REG_CNT must be at least 4");
      end
      if (PC_IDX >= REG_CNT || SP_IDX >= REG_CNT || ABS_IDX >= REG_CNT) begin : g_bad_idx
         $error("opnd_ea_gen: special register index out of range");
      end
      if (PC_IDX == SP_IDX || PC_IDX == ABS_IDX || SP_IDX == ABS_IDX) begin : g_dup_idx
         $error("opnd_ea_gen: special register indices must differ");
      end
   endgenerate

   ea_mode_e          mode;
   ea_kind_e          kind_c;
   logic [DATA_W-1:0] base;
   logic [DATA_W-1:0] addr_c;
   logic [DATA_W-1:0] imm_c;
   logic              wb_en_c;
   logic [REG_W-1:0]  wb_rn_c;
   logic [DATA_W-1:0] wb_val_c;

   assign base = (req_reg == REG_W'(PC_IDX)) ? req_pc : req_regval;

   opnd_ea_decode #(
      .REG_W   (REG_W),
      .PC_IDX  (PC_IDX),
      .ABS_IDX (ABS_IDX)
   ) u_decode (
      .dst        (req_dst),
      .mode_field (req_mode),
      .rn         (req_reg),
      .mode       (mode)
   );

   opnd_ea_addr #(
      .DATA_W      (DATA_W),
      .SHARE_ADDER (SHARE_ADDER)
   ) u_addr (
      .mode (mode),
      .ext  (req_ext),
      .pc   (req_pc),
      .base (base),
      .kind (kind_c),
      .addr (addr_c),
      .imm  (imm_c)
   );

   opnd_ea_step #(
      .DATA_W (DATA_W),
      .REG_W  (REG_W),
      .SP_IDX (SP_IDX),
      .PC_IDX (PC_IDX)
   ) u_step (
      .mode    (mode),
      .rn      (req_reg),
      .byte_op (req_byte),
      .base    (base),
      .wb_en   (wb_en_c),
      .wb_rn   (wb_rn_c),
      .wb_val  (wb_val_c)
   );

   always_ff @(posedge clk) begin
      if (!rst_n || !req_valid) begin
         ea_valid   <= 1'b0;
         ea_kind    <= 2'd0;
         ea_reg     <= '0;
         ea_addr    <= '0;
         ea_imm     <= '0;
         ea_illegal <= 1'b0;
         wb_valid   <= 1'b0;
         wb_reg     <= '0;
         wb_data    <= '0;
      end else begin
         ea_valid   <= 1'b1;
         ea_kind    <= kind_c;
         ea_reg     <= (kind_c == KIND_REG) ? req_reg : '0;
         ea_addr    <= addr_c;
         ea_imm     <= imm_c;
         ea_illegal <= (kind_c == KIND_NONE);
         wb_valid   <= wb_en_c;
         wb_reg     <= wb_rn_c;
         wb_data    <= wb_val_c;
      end
   end

   AST_STROBE_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> ea_valid) else $error("strobe missing");                          // R9
   AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !ea_valid) else $error("strobe without request");                // R9
   AST_WB_IN_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      wb_valid |-> ea_valid) else $error("write-back outside strobe");               // R9
   AST_DST_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_dst && req_mode[1]) |=> (ea_illegal && !wb_valid))
      else $error("illegal destination not flagged");                                 // R2
   AST_IMM_PC_WB: assert property (@(posedge clk) disable iff (!rst_n)
      (ea_valid && ea_kind == 2'd2) |-> (wb_valid && wb_reg == REG_W'(PC_IDX)))
      else $error("immediate without pc write-back");                                  // R6
   AST_SP_STEP_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_valid && wb_reg == REG_W'(SP_IDX)) |->
         (DATA_W'(wb_data - $past(req_regval)) == DATA_W'(WORD_STEP)))
      else $error("stack pointer step wrong");                                         // R8

endmodule

// File: tb/opnd_ea_gen_bench.sv
`timescale 1ns/1ps
module opnd_ea_gen_bench;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        req_valid, req_dst, req_byte;
   logic [1:0]  req_mode;
   logic [3:0]  req_reg;
   logic [15:0] req_ext, req_pc, req_regval;
   logic        ea_valid, ea_illegal, wb_valid;
   logic [1:0]  ea_kind;
   logic [3:0]  ea_reg, wb_reg;
   logic [15:0] ea_addr, ea_imm, wb_data;

   logic [15:0] regs [16];
   int n_tests = 0;
   int n_fail  = 0;

   always #2 clk = ~clk;

   opnd_ea_gen u_opnd_ea_gen (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_dst(req_dst),
      .req_mode(req_mode), .req_reg(req_reg), .req_byte(req_byte),
      .req_ext(req_ext), .req_pc(req_pc), .req_regval(req_regval),
      .ea_valid(ea_valid), .ea_kind(ea_kind), .ea_reg(ea_reg),
      .ea_addr(ea_addr), .ea_imm(ea_imm), .ea_illegal(ea_illegal),
      .wb_valid(wb_valid), .wb_reg(wb_reg), .wb_data(wb_data)
   );

   task automatic chk(input string tag, input string what,
                      input logic [15:0] act, input logic [15:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic chk_idle(input string tag);
      chk(tag, "ea_valid", 16'(ea_valid), 16'h0);
      chk(tag, "ea_kind", 16'(ea_kind), 16'h0);
      chk(tag, "ea_reg", 16'(ea_reg), 16'h0);
      chk(tag, "ea_addr", ea_addr, 16'h0);
      chk(tag, "ea_imm", ea_imm, 16'h0);
      chk(tag, "ea_illegal", 16'(ea_illegal), 16'h0);
      chk(tag, "wb_valid", 16'(wb_valid), 16'h0);
      chk(tag, "wb_reg", 16'(wb_reg), 16'h0);
      chk(tag, "wb_data", wb_data, 16'h0);
   endtask

   // One request; PC comes from regs[0], register contents from regs[rn].
   task automatic issue(input string tag, input logic dst, input logic [1:0] mode,
                        input logic [3:0] rn, input logic by, input logic [15:0] ext,
                        input logic [1:0] ekind, input logic [3:0] ereg,
                        input logic [15:0] eaddr, input logic [15:0] eimm,
                        input logic ewb, input logic [3:0] ewbreg,
                        input logic [15:0] ewbdata);
      @(negedge clk);
      req_valid  = 1'b1;
      req_dst    = dst;
      req_mode   = mode;
      req_reg    = rn;
      req_byte   = by;
      req_ext    = ext;
      req_pc     = regs[0];
      req_regval = regs[rn];
      @(posedge clk);
      #1;
      req_valid = 1'b0;
      chk(tag, "ea_valid", 16'(ea_valid), 16'h1);
      chk(tag, "ea_kind", 16'(ea_kind), 16'(ekind));
      chk(tag, "ea_reg", 16'(ea_reg), 16'(ereg));
      chk(tag, "ea_addr", ea_addr, eaddr);
      chk(tag, "ea_imm", ea_imm, eimm);
      chk(tag, "ea_illegal", 16'(ea_illegal), 16'(ekind == 2'd3));
      chk(tag, "wb_valid", 16'(wb_valid), 16'(ewb));
      chk(tag, "wb_reg", 16'(wb_reg), 16'(ewbreg));
      chk(tag, "wb_data", wb_data, ewbdata);
      if (wb_valid) regs[wb_reg] = wb_data;
   endtask

   task automatic t_reset;
      chk_idle("R10");
   endtask

   task automatic t_register;
      regs[5] = 16'h1111;
      issue("R1", 1'b0, 2'b00, 4'd5, 1'b0, 16'hAAAA, 2'd0, 4'd5, 16'h0, 16'h0, 1'b0, 4'd0, 16'h0);
      issue("R1", 1'b1, 2'b00, 4'd9, 1'b1, 16'h1234, 2'd0, 4'd9, 16'h0, 16'h0, 1'b0, 4'd0, 16'h0);
   endtask

   task automatic t_indexed;
      regs[6] = 16'h1200;
      regs[7] = 16'hFFF0;
      issue("R3", 1'b0, 2'b01, 4'd6, 1'b0, 16'h0034, 2'd1, 4'd0, 16'h1234, 16'h0, 1'b0, 4'd0, 16'h0);
      issue("R3", 1'b1, 2'b01, 4'd7, 1'b1, 16'h0020, 2'd1, 4'd0, 16'h0010, 16'h0, 1'b0, 4'd0, 16'h0);
   endtask

   task automatic t_symbolic;
      regs[0] = 16'hC010;
      issue("R4", 1'b0, 2'b01, 4'd0, 1'b0, 16'h0100, 2'd1, 4'd0, 16'hC110, 16'h0, 1'b0, 4'd0, 16'h0);
      issue("R4", 1'b1, 2'b01, 4'd0, 1'b0, 16'h4000, 2'd1, 4'd0, 16'h0010, 16'h0, 1'b0, 4'd0, 16'h0);
   endtask

   task automatic t_absolute;
      regs[2] = 16'h5555;
      issue("R5", 1'b0, 2'b01, 4'd2, 1'b0, 16'h0200, 2'd1, 4'd0, 16'h0200, 16'h0, 1'b0, 4'd0, 16'h0);
      issue("R5", 1'b1, 2'b01, 4'd2, 1'b1, 16'h0021, 2'd1, 4'd0, 16'h0021, 16'h0, 1'b0, 4'd0, 16'h0);
   endtask

   task automatic t_indirect;
      regs[9] = 16'h0300;
      issue("R7", 1'b0, 2'b10, 4'd9, 1'b0, 16'h7777, 2'd1, 4'd0, 16'h0300, 16'h0, 1'b0, 4'd0, 16'h0);
   endtask

   task automatic t_autoinc;
      regs[10] = 16'h0400;
      issue("R8", 1'b0, 2'b11, 4'd10, 1'b0, 16'h0, 2'd1, 4'd0, 16'h0400, 16'h0, 1'b1, 4'd10, 16'h0402);
      issue("R8", 1'b0, 2'b11, 4'd10, 1'b0, 16'h0, 2'd1, 4'd0, 16'h0402, 16'h0, 1'b1, 4'd10, 16'h0404);
      regs[11] = 16'h0501;
      issue("R8", 1'b0, 2'b11, 4'd11, 1'b1, 16'h0, 2'd1, 4'd0, 16'h0501, 16'h0, 1'b1, 4'd11, 16'h0502);
      regs[1] = 16'h0280;
      issue("R8", 1'b0, 2'b11, 4'd1, 1'b1, 16'h0, 2'd1, 4'd0, 16'h0280, 16'h0, 1'b1, 4'd1, 16'h0282);
      regs[12] = 16'hFFFF;
      issue("R8", 1'b0, 2'b11, 4'd12, 1'b0, 16'h0, 2'd1, 4'd0, 16'hFFFF, 16'h0, 1'b1, 4'd12, 16'h0001);
   endtask

   task automatic t_immediate;
      regs[0] = 16'hC020;
      issue("R6", 1'b0, 2'b11, 4'd0, 1'b1, 16'hBEEF, 2'd2, 4'd0, 16'h0, 16'hBEEF, 1'b1, 4'd0, 16'hC022);
      issue("R6", 1'b0, 2'b11, 4'd0, 1'b0, 16'h0042, 2'd2, 4'd0, 16'h0, 16'h0042, 1'b1, 4'd0, 16'hC024);
   endtask

   task automatic t_dst_illegal;
      regs[13] = 16'h0600;
      issue("R2", 1'b1, 2'b10, 4'd13, 1'b0, 16'h0050, 2'd3, 4'd0, 16'h0, 16'h0, 1'b0, 4'd0, 16'h0);
      issue("R2", 1'b1, 2'b11, 4'd13, 1'b0, 16'h0050, 2'd3, 4'd0, 16'h0, 16'h0, 1'b0, 4'd0, 16'h0);
      issue("R2", 1'b1, 2'b11, 4'd0, 1'b0, 16'h0050, 2'd3, 4'd0, 16'h0, 16'h0, 1'b0, 4'd0, 16'h0);
      chk("R2", "r13 untouched", regs[13], 16'h0600);
   endtask

   task automatic t_timing;
      regs[14] = 16'h0700;
      issue("R9", 1'b0, 2'b11, 4'd14, 1'b0, 16'h0, 2'd1, 4'd0, 16'h0700, 16'h0, 1'b1, 4'd14, 16'h0702);
      issue("R9", 1'b0, 2'b10, 4'd14, 1'b0, 16'h0, 2'd1, 4'd0, 16'h0702, 16'h0, 1'b0, 4'd0, 16'h0);
      @(posedge clk);
      #1;
      chk_idle("R9");
   endtask

   initial begin : watchdog
      #800000;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      for (int i = 0; i < 16; i++) regs[i] = 16'h0;
      rst_n = 1'b0; req_valid = 1'b0; req_dst = 1'b0; req_mode = 2'b00;
      req_reg = 4'd0; req_byte = 1'b0; req_ext = 16'h0; req_pc = 16'h0; req_regval = 16'h0;
      repeat (3) @(posedge clk);
      #1;
      t_reset();
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      #1;
      t_reset();
      t_register();
      t_indexed();
      t_symbolic();
      t_absolute();
      t_indirect();
      t_autoinc();
      t_immediate();
      t_dst_illegal();
      t_timing();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule